// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block watches an asynchronous capture pin and records when it changes. On the selected transition it copies the value of a free-running 16-bit counter into a capture register and sets a capture flag. It asserts an interrupt request while the flag is set and interrupts are enabled. The counter is not part of this block; its value arrives on an input port.

The pin first passes through a two-flop synchronizer. An optional noise filter can be switched in after that. When the filter is on, it only accepts a new pin level after four consecutive identical samples. This delays every capture by exactly four clock cycles compared with the unfiltered path. When the timer is using the capture register as its period limit, it says so through a mode input, and captures are blocked for as long as that input is high.

Software clears the flag with a one-cycle strobe. A capture that lands in the same cycle as the strobe wins, and the flag stays set.

Top module: `icap_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `cap_o` is 0 and `flag_o` and `irq_o` are 0. The synchronized and filtered pin levels reset low.
- R2: With `edge_rise_i`=0 and the filter off, a high-to-low pin change loads `cap_o` and sets `flag_o` on the second rising clock edge after the edge that first samples the new level. The value loaded is the `count_i` present at that edge.
- R3: With `edge_rise_i`=1, a low-to-high change captures with the R2 timing. A change in the unselected direction leaves `cap_o` and `flag_o` unchanged.
- R4: With `filt_en_i`=1, a pin level held for at least four clock cycles captures exactly four clock cycles later than on the unfiltered path.
- R5: With `filt_en_i`=1, a pin level held for fewer than four clock cycles is ignored: no capture and no flag.
- R6: `flag_o` stays set until a clock edge at which `flag_clr_i` is high, and is 0 after that edge.
- R7: When a capture and `flag_clr_i` fall on the same clock edge, `flag_o` is 1 after that edge and `cap_o` holds the new value.
- R8: `irq_o` is high exactly when `flag_o` and `irq_en_i` are both high.
- R9: While `cap_is_top_i` is high, a selected edge changes neither `cap_o` nor `flag_o`.
- R10: Toggling `edge_rise_i` while the pin level is steady never causes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | 16 | Running counter value |
| filt_en_i | input | 1 | 1 switches the four-sample noise filter in |
| edge_rise_i | input | 1 | 0 selects falling edges, 1 selects rising edges |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle strobe that clears the flag |
| cap_is_top_i | input | 1 | 1 when the capture register serves as the timer period; blocks captures |
| cap_o | output | 16 | Capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The vector walk sweeps all combinations of edge direction and selected polarity, with and without the filter. It counts the captured value exactly, so it separates the two-cycle unfiltered latency from the six-cycle filtered latency, and a matching edge from an ignored one. Directed runs check the filter threshold from both sides:
- a three-cycle pulse must vanish;
- a four-cycle pulse must capture.

They also line a capture up with the clear strobe on the same edge, block captures with the period mode, and toggle the edge polarity while the pin level is steady.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned SYNC_DEF    = 2;
  localparam int unsigned FILT_LEN_DEF = 4;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned HW = LEN - 1;

  logic [HW-1:0] hist_q;
  logic          lvl_q;
  logic          all_hi, all_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (HW == 1) hist_q <= d_i;
    else hist_q <= {hist_q[HW-2:0], d_i};
  end

  // current sample plus LEN-1 stored samples must agree
  assign all_hi = d_i & (&hist_q);
  assign all_lo = ~d_i & ~(|hist_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else if (all_hi) lvl_q <= 1'b1;
    else if (all_lo) lvl_q <= 1'b0;
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= lvl_i;
  end

  // direction taken from the level itself, so a select change alone cannot fire
  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = lvl_i & ~prev_q;
      default:   hit_o = ~lvl_i & prev_q;
    endcase
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned SYNC     = SYNC_DEF,
  parameter int unsigned FILT_LEN = FILT_LEN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  input  logic             cap_is_top_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic             pin_s;
  logic             pin_f;
  logic             lvl;
  logic             hit;
  logic             cap_ev;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;
  edge_sel_e        sel;

  icap_sync #(.STAGES(SYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_s),
    .q_o   (pin_f)
  );

  assign lvl = filt_en_i ? pin_f : pin_s;
  assign sel = edge_sel_e'(edge_rise_i);

  icap_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .sel_i (sel),
    .hit_o (hit)
  );

  assign cap_ev = hit & ~cap_is_top_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= '0;
    else if (cap_ev) cap_q <= count_i;
  end

  // capture outranks clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (cap_ev) flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_i,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic             cap_is_top_i,
  input logic [CNT_W-1:0] cap_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic             lvl,
  input logic             cap_ev
);
  assert_cap_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> cap_o == $past(count_i));

  assert_flag_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  assert_flag_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && flag_clr_i && !cap_ev |=> !flag_o);

  assert_cap_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> flag_o);

  assert_irq_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o && irq_en_i);

  assert_top_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_is_top_i |=> $stable(cap_o) && !$rose(flag_o));

  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(lvl) |-> !cap_ev);
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .count_i     (count_i),
  .irq_en_i    (irq_en_i),
  .flag_clr_i  (flag_clr_i),
  .cap_is_top_i(cap_is_top_i),
  .cap_o       (cap_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o),
  .lvl         (lvl),
  .cap_ev      (cap_ev)
);

// File: tb/icap_unit_tb.sv
`timescale 1ns/1ps
module icap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] count = '0;
  logic        filt_en = 1'b0, edge_rise = 1'b0, irq_en = 1'b0, clr = 1'b0, is_top = 1'b0;
  logic [15:0] cap;
  logic        flag, irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  icap_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .count_i(count),
    .filt_en_i(filt_en), .edge_rise_i(edge_rise), .irq_en_i(irq_en),
    .flag_clr_i(clr), .cap_is_top_i(is_top),
    .cap_o(cap), .flag_o(flag), .irq_o(irq)
  );

  initial forever begin
    @(negedge clk);
    count <= count + 16'd1;
  end

  // {filt_en, edge_rise, new_pin, expect_cap, latency[3:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b0_0_1_0_0000,
    8'b0_0_0_1_0010,
    8'b0_1_1_1_0010,
    8'b0_1_0_0_0000,
    8'b1_1_1_1_0110,
    8'b1_0_0_1_0110,
    8'b1_0_1_0_0000,
    8'b1_1_0_0_0000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_pin(input logic v, output logic [15:0] c0);
    @(negedge clk);
    #1;
    pin = v;
    c0 = count;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    #1 clr = 1'b1;
    @(negedge clk);
    #1 clr = 1'b0;
  endtask

  initial begin
    logic [15:0] c0, prev;
    cyc(3);
    chk("R1 cap in reset", cap, 0);
    chk("R1 flag in reset", flag, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 cap after reset", cap, 0);
    chk("R1 flag after reset", flag, 0);

    for (int i = 0; i < 8; i++) begin
      string req;
      pulse_clr();
      prev = cap;
      filt_en = VEC[i][7];
      edge_rise = VEC[i][6];
      req = VEC[i][7] ? "R4" : (VEC[i][6] ? "R3" : "R2");
      set_pin(VEC[i][5], c0);
      cyc(12);
      chk({req, " flag"}, flag, VEC[i][4]);
      chk({req, " cap"}, cap, VEC[i][4] ? c0 + 16'(VEC[i][3:0]) : prev);
    end

    // R6 / R8
    pulse_clr();
    filt_en = 1'b0; edge_rise = 1'b1; irq_en = 1'b0;
    set_pin(1'b1, c0);
    cyc(6);
    chk("R6 flag held", flag, 1);
    chk("R8 irq masked", irq, 0);
    irq_en = 1'b1;
    #1;
    chk("R8 irq enabled", irq, 1);
    pulse_clr();
    #1;
    chk("R6 flag cleared", flag, 0);
    chk("R8 irq after clear", irq, 0);

    // R7: capture on same edge as clear
    edge_rise = 1'b0;
    set_pin(1'b0, c0);
    cyc(6);
    chk("R7 setup flag", flag, 1);
    edge_rise = 1'b1;
    set_pin(1'b1, c0);
    @(negedge clk);
    @(negedge clk);
    #1 clr = 1'b1;
    @(negedge clk);
    #1 clr = 1'b0;
    chk("R7 flag kept", flag, 1);
    chk("R7 cap new", cap, c0 + 16'd2);
    pulse_clr();
    #1;
    chk("R6 clear alone", flag, 0);

    // R9
    prev = cap;
    is_top = 1'b1; edge_rise = 1'b0;
    set_pin(1'b0, c0);
    cyc(8);
    chk("R9 flag blocked", flag, 0);
    chk("R9 cap blocked", cap, prev);
    is_top = 1'b0;

    // R10
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1 edge_rise = ~edge_rise;
    end
    cyc(4);
    chk("R10 no spurious flag", flag, 0);
    chk("R10 cap unchanged", cap, prev);

    // R5: three-cycle glitch under filter
    filt_en = 1'b1; edge_rise = 1'b1;
    cyc(6);
    set_pin(1'b1, c0);
    cyc(3);
    pin = 1'b0;
    cyc(10);
    chk("R5 short pulse flag", flag, 0);
    chk("R5 short pulse cap", cap, prev);

    // R4 boundary: four-cycle pulse passes
    set_pin(1'b1, c0);
    cyc(4);
    pin = 1'b0;
    cyc(10);
    chk("R4 four-cycle flag", flag, 1);
    chk("R4 four-cycle cap", cap, c0 + 16'd6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule